// File: doc/BRIEF.md
# PCI configuration access port

This host-side register block turns processor accesses into configuration cycles. Software first writes a configuration address register, then reads or writes a data window. Each data-window access becomes one request on a simple downstream valid/ready interface, and reads wait for a response. The top bit of the address register gates the data window. The byte offset of a sub-word access is merged into the downstream address, and data crosses the window in little-endian lane order.

The same 4 KB region also holds plain storage: four outbound and three inbound address-translation register sets, and one timer word. Nothing in that storage drives other logic. A separate combinational path folds the interrupt pins of two device slots onto four shared interrupt lines, using a fixed slot-based rotation.

The processor side uses a request held until a one-cycle acknowledge. Register accesses complete in two cycles. Window accesses complete when the downstream side accepts a write or returns read data.

Top module: `cfg_access_port`

## Requirements
- R1: A write to offset 0x000 stores the value with bits 1:0 cleared; a read of 0x000 returns the stored value.
- R2: A data-window read (offsets 0x004–0x007) while stored address bit 31 is 0 returns 0xFFFFFFFF and starts no downstream request.
- R3: A data-window write while stored address bit 31 is 0 is dropped: no downstream request is made and the access is still acknowledged.
- R4: With bit 31 set, a data-window access issues one request whose address is the stored address ORed with access offset bits 1:0. Its size code equals the access size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) and its write flag matches the access.
- R5: Data crosses the window in little-endian order in both directions. For 4 bytes, all four bytes are reversed. For 2 bytes, bits 7:0 and 15:8 are exchanged and the upper half is zero. For 1 byte, bits 7:0 pass through and the rest is zero.
- R6: A downstream request holds valid and its payload stable until ready. At most one request is outstanding. A read is acknowledged only after the response is returned.
- R7: Four outbound sets at 0xC20 + 0x20·n (n = 0..3) each store four words at relative offsets 0x0, 0x4, 0x8 and 0x10, and read them back.
- R8: Three inbound sets at 0xDA0 + 0x20·n (n = 0..2) each store four words at relative offsets 0x0, 0x8, 0xC and 0x10, and read them back.
- R9: The timer word at 0xE20 stores and reads back a full 32-bit value.
- R10: Any other offset, including 0x008 and 0x00C, reads 0, and writes to it change no stored word.
- R11: Pin p (0..3) of slot 0x11 drives line (p+1) mod 4. Pin p of slot 0x12 drives line (p+2) mod 4. The catch-all input from other slots drives line 0. Each line is the OR of its sources.
- R12: Every access gets exactly one acknowledge pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, held until acknowledge |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 12 | Byte offset within the region |
| cpu_size_i | input | 2 | Access size code (0 = 1 B, 1 = 2 B, 2 = 4 B) |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, valid with acknowledge |
| cfg_valid_o | output | 1 | Downstream request valid |
| cfg_ready_i | input | 1 | Downstream request accepted |
| cfg_we_o | output | 1 | Downstream write flag |
| cfg_addr_o | output | 32 | Downstream configuration address |
| cfg_size_o | output | 2 | Downstream size code |
| cfg_wdata_o | output | 32 | Downstream write data, lane-swapped |
| cfg_rvalid_i | input | 1 | Downstream read response valid |
| cfg_rdata_i | input | 32 | Downstream read response data |
| slot_irq_i | input | 8 | Interrupt pins, slot 0x11 in bits 3:0, slot 0x12 in bits 7:4 |
| stray_irq_i | input | 1 | Interrupt from any other slot |
| irq_o | output | 4 | Shared interrupt lines |

## Verification
A corrupted address register shows up on the next data-window access. It can appear as a wrong downstream address, as a request that should have been blocked, or as a read of the register itself. A sequencer stuck between states shows up within a few cycles as a missing or repeated acknowledge, or as a valid that drops before ready. A wrong decode in the window storage only shows when the aliased word is read back. For that reason the bench writes a distinct value at every word offset of the storage range before reading any of them. The interrupt folding is combinational, so a wrong route is visible as soon as the input changes, and all 512 input combinations are swept.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_DONE} seq_state_e;

  // little-endian lane order across the window
  function automatic logic [31:0] lane_swap(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_swap = {24'h0, d[7:0]};
      SZ_HALF: lane_swap = {16'h0, d[7:0], d[15:8]};
      default: lane_swap = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_port_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        dwin_i,
  input  logic        en_i,
  input  logic [31:0] tgt_addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] loc_rdata_i,
  output logic        loc_we_o,
  output logic        ack_o,
  output logic [31:0] rdata_o,
  output logic        cfg_valid_o,
  input  logic        cfg_ready_i,
  output logic        cfg_we_o,
  output logic [31:0] cfg_addr_o,
  output logic [1:0]  cfg_size_o,
  output logic [31:0] cfg_wdata_o,
  input  logic        cfg_rvalid_i,
  input  logic [31:0] cfg_rdata_i
);
  seq_state_e  state_q;
  logic [31:0] rdata_q, addr_q, wdata_q;
  logic [1:0]  size_q;
  logic        we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          if (dwin_i && en_i) begin
            state_q <= ST_REQ;
            addr_q  <= tgt_addr_i;
            wdata_q <= lane_swap(wdata_i, size_i);
            size_q  <= size_i;
            we_q    <= we_i;
          end else begin
            rdata_q <= dwin_i ? 32'hFFFF_FFFF : loc_rdata_i;
            state_q <= ST_DONE;
          end
        end
        ST_REQ: if (cfg_ready_i) state_q <= we_q ? ST_DONE : ST_RSP;
        ST_RSP: if (cfg_rvalid_i) begin
          rdata_q <= lane_swap(cfg_rdata_i, size_q);
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign loc_we_o    = (state_q == ST_IDLE) && req_i && we_i && !dwin_i;
  assign ack_o       = (state_q == ST_DONE);
  assign rdata_o     = rdata_q;
  assign cfg_valid_o = (state_q == ST_REQ);
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = addr_q;
  assign cfg_size_o  = size_q;
  assign cfg_wdata_o = wdata_q;
endmodule

// File: rtl/win_regs.sv
module win_regs #(
  parameter int AW      = 12,
  parameter int NUM_OB  = 4,
  parameter int NUM_IB  = 3,
  parameter int OB_BASE = 'hC20,
  parameter int IB_BASE = 'hDA0,
  parameter int TMR_OFF = 'hE20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] off_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  localparam int OBW = (NUM_OB > 1) ? $clog2(NUM_OB) : 1;
  localparam int IBW = (NUM_IB > 1) ? $clog2(NUM_IB) : 1;
  localparam int SW  = AW - 5;

  logic [31:0] ob_q [NUM_OB][4];
  logic [31:0] ib_q [NUM_IB][4];
  logic [31:0] tmr_q;

  logic           ob_hit, ib_hit, tmr_hit;
  logic [OBW-1:0] ob_idx;
  logic [IBW-1:0] ib_idx;
  logic [1:0]     ob_w, ib_w;
  logic           ob_wok, ib_wok;

  // word select inside a 32-byte set from offset bits 4:2
  always_comb begin
    ob_wok = 1'b1;
    ob_w   = 2'd0;
    case (off_i[4:2])
      3'd0: ob_w = 2'd0;
      3'd1: ob_w = 2'd1;
      3'd2: ob_w = 2'd2;
      3'd4: ob_w = 2'd3;
      default: ob_wok = 1'b0;
    endcase
    ib_wok = 1'b1;
    ib_w   = 2'd0;
    case (off_i[4:2])
      3'd0: ib_w = 2'd0;
      3'd2: ib_w = 2'd1;
      3'd3: ib_w = 2'd2;
      3'd4: ib_w = 2'd3;
      default: ib_wok = 1'b0;
    endcase
  end

  always_comb begin
    ob_hit = 1'b0;
    ob_idx = '0;
    for (int i = 0; i < NUM_OB; i++) begin
      if (off_i[AW-1:5] == SW'(OB_BASE / 32 + i)) begin
        ob_hit = ob_wok;
        ob_idx = OBW'(i);
      end
    end
    ib_hit = 1'b0;
    ib_idx = '0;
    for (int i = 0; i < NUM_IB; i++) begin
      if (off_i[AW-1:5] == SW'(IB_BASE / 32 + i)) begin
        ib_hit = ib_wok;
        ib_idx = IBW'(i);
      end
    end
    tmr_hit = (off_i[AW-1:2] == (AW-2)'(TMR_OFF / 4));
  end

  for (genvar s = 0; s < NUM_OB; s++) begin : g_ob
    for (genvar w = 0; w < 4; w++) begin : g_w
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ob_q[s][w] <= '0;
        else if (we_i && ob_hit && ob_idx == OBW'(s) && ob_w == 2'(w)) ob_q[s][w] <= wdata_i;
      end
    end
  end

  for (genvar s = 0; s < NUM_IB; s++) begin : g_ib
    for (genvar w = 0; w < 4; w++) begin : g_w
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ib_q[s][w] <= '0;
        else if (we_i && ib_hit && ib_idx == IBW'(s) && ib_w == 2'(w)) ib_q[s][w] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else if (we_i && tmr_hit) tmr_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (ob_hit)       rdata_o = ob_q[ob_idx][ob_w];
    else if (ib_hit)  rdata_o = ib_q[ib_idx][ib_w];
    else if (tmr_hit) rdata_o = tmr_q;
  end
endmodule

// File: rtl/irq_fold.sv
module irq_fold #(
  parameter int NUM_SLOT   = 2,
  parameter int FIRST_SLOT = 'h11
) (
  input  logic [NUM_SLOT*4-1:0] slot_irq_i,
  input  logic                  stray_irq_i,
  output logic [3:0]            irq_o
);
  function automatic int line_of(input int slot, input int pin);
    if (slot == 'h11 || slot == 'h12) line_of = (pin + slot - 'h10) % 4;
    else line_of = 0;
  endfunction

  always_comb begin
    irq_o    = 4'b0;
    irq_o[0] = stray_irq_i;
    for (int s = 0; s < NUM_SLOT; s++)
      for (int p = 0; p < 4; p++)
        if (slot_irq_i[s*4+p]) irq_o[line_of(FIRST_SLOT + s, p)] = 1'b1;
  end
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter int AW         = 12,
  parameter int NUM_OB     = 4,
  parameter int NUM_IB     = 3,
  parameter int NUM_SLOT   = 2,
  parameter int FIRST_SLOT = 'h11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_req_i,
  input  logic                  cpu_we_i,
  input  logic [AW-1:0]         cpu_addr_i,
  input  logic [1:0]            cpu_size_i,
  input  logic [31:0]           cpu_wdata_i,
  output logic                  cpu_ack_o,
  output logic [31:0]           cpu_rdata_o,
  output logic                  cfg_valid_o,
  input  logic                  cfg_ready_i,
  output logic                  cfg_we_o,
  output logic [31:0]           cfg_addr_o,
  output logic [1:0]            cfg_size_o,
  output logic [31:0]           cfg_wdata_o,
  input  logic                  cfg_rvalid_i,
  input  logic [31:0]           cfg_rdata_i,
  input  logic [NUM_SLOT*4-1:0] slot_irq_i,
  input  logic                  stray_irq_i,
  output logic [3:0]            irq_o
);
  logic [31:0] caddr_q, win_rdata, loc_rdata;
  logic        grp0, is_areg, is_dwin, loc_we;

  assign grp0    = (cpu_addr_i[AW-1:4] == '0);
  assign is_areg = grp0 && (cpu_addr_i[3:2] == 2'd0);
  assign is_dwin = grp0 && (cpu_addr_i[3:2] == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) caddr_q <= '0;
    else if (loc_we && is_areg) caddr_q <= {cpu_wdata_i[31:2], 2'b00};
  end

  assign loc_rdata = is_areg ? caddr_q : (grp0 ? 32'h0 : win_rdata);

  cfg_seq u_seq (
    .clk_i, .rst_ni,
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .dwin_i      (is_dwin),
    .en_i        (caddr_q[31]),
    .tgt_addr_i  (caddr_q | {30'h0, cpu_addr_i[1:0]}),
    .size_i      (cpu_size_i),
    .wdata_i     (cpu_wdata_i),
    .loc_rdata_i (loc_rdata),
    .loc_we_o    (loc_we),
    .ack_o       (cpu_ack_o),
    .rdata_o     (cpu_rdata_o),
    .cfg_valid_o, .cfg_ready_i, .cfg_we_o, .cfg_addr_o,
    .cfg_size_o, .cfg_wdata_o, .cfg_rvalid_i, .cfg_rdata_i
  );

  win_regs #(.AW(AW), .NUM_OB(NUM_OB), .NUM_IB(NUM_IB)) u_win (
    .clk_i, .rst_ni,
    .we_i    (loc_we && !grp0),
    .off_i   (cpu_addr_i),
    .wdata_i (cpu_wdata_i),
    .rdata_o (win_rdata)
  );

  irq_fold #(.NUM_SLOT(NUM_SLOT), .FIRST_SLOT(FIRST_SLOT)) u_irq (
    .slot_irq_i, .stray_irq_i, .irq_o
  );
endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk #(
  parameter int NSI = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cpu_ack_o,
  input logic           cfg_valid_o,
  input logic           cfg_ready_i,
  input logic           cfg_we_o,
  input logic [31:0]    cfg_addr_o,
  input logic [1:0]     cfg_size_o,
  input logic [31:0]    cfg_wdata_o,
  input logic [NSI-1:0] slot_irq_i,
  input logic           stray_irq_i,
  input logic [3:0]     irq_o
);
  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> cfg_addr_o[31]);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_addr_o) && $stable(cfg_wdata_o)
      && $stable(cfg_we_o) && $stable(cfg_size_o));

  p_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && cfg_ready_i |=> !cfg_valid_o);

  p_ack_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> !cfg_valid_o);

  p_ack_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);

  p_stray_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stray_irq_i |-> irq_o[0]);

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_irq_i == '0 && !stray_irq_i) |-> irq_o == 4'b0);
endmodule

bind cfg_access_port cfg_access_port_chk #(.NSI(NUM_SLOT*4)) u_chk (
  .clk_i, .rst_ni, .cpu_ack_o, .cfg_valid_o, .cfg_ready_i, .cfg_we_o,
  .cfg_addr_o, .cfg_size_o, .cfg_wdata_o, .slot_irq_i, .stray_irq_i, .irq_o
);

// File: tb/tb_cfg_access_port.sv
`timescale 1ns/1ps
module tb_cfg_access_port;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [11:0] cpu_addr_i = '0;
  logic [1:0]  cpu_size_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_ack_o;
  logic [31:0] cpu_rdata_o;
  logic        cfg_valid_o, cfg_we_o;
  logic        cfg_ready_i = 1'b0, cfg_rvalid_i = 1'b0;
  logic [31:0] cfg_addr_o, cfg_wdata_o;
  logic [31:0] cfg_rdata_i = '0;
  logic [1:0]  cfg_size_o;
  logic [7:0]  slot_irq_i = '0;
  logic        stray_irq_i = 1'b0;
  logic [3:0]  irq_o;

  always #2.5 clk_i = ~clk_i;

  cfg_access_port dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swz(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return d & 32'hFF;
    if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'd1, ~a[7:0], a[7:0]};
  endfunction

  // downstream responder
  int ready_lat = 0, rsp_lat = 0, dn_count = 0, hold_err = 0;
  logic [31:0] dn_addr, dn_wdata;
  logic [1:0]  dn_size;
  logic        dn_we;
  initial begin
    int wait_c = 0, rw = 0;
    bit due = 0, prev_v = 0;
    logic [31:0] pa = '0;
    logic [31:0] rsp_addr = '0;
    forever begin
      @(negedge clk_i);
      cfg_ready_i  = 1'b0;
      cfg_rvalid_i = 1'b0;
      if (cfg_valid_o && prev_v && cfg_addr_o != pa) hold_err++;
      prev_v = cfg_valid_o;
      pa = cfg_addr_o;
      if (due) begin
        if (rw == 0) begin
          cfg_rvalid_i = 1'b1;
          cfg_rdata_i  = model_rd(rsp_addr);
          due = 0;
        end else rw--;
      end else if (cfg_valid_o) begin
        if (wait_c >= ready_lat) begin
          cfg_ready_i = 1'b1;
          dn_count++;
          dn_addr = cfg_addr_o; dn_wdata = cfg_wdata_o;
          dn_size = cfg_size_o; dn_we = cfg_we_o;
          prev_v = 0;
          wait_c = 0;
          if (!cfg_we_o) begin due = 1; rw = rsp_lat; rsp_addr = cfg_addr_o; end
        end else wait_c++;
      end
    end
  end

  task automatic xfer(input logic we, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd);
    int n = 0;
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_size_i = sz; cpu_wdata_i = wd;
    do begin @(negedge clk_i); n++; end while (!cpu_ack_o && n < 200);
    rd = cpu_rdata_o;
    cpu_req_i = 1'b0;
    check(n < 200, "R12 ack timeout", 32'(n), 32'd200);
    @(negedge clk_i);
    check(!cpu_ack_o, "R12 single pulse", {31'h0, cpu_ack_o}, 32'h0);
  endtask

  function automatic bit mapped(input int off);
    int r;
    if (off >= 'hC20 && off < 'hCA0) begin
      r = (off - 'hC20) % 32;
      return r == 0 || r == 4 || r == 8 || r == 'h10;
    end
    if (off >= 'hDA0 && off < 'hE00) begin
      r = (off - 'hDA0) % 32;
      return r == 0 || r == 8 || r == 'hC || r == 'h10;
    end
    return off == 'hE20;
  endfunction

  initial begin
    #500000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, a, wd, exp;
    int c0;
    repeat (3) @(negedge clk_i);
    check(cpu_ack_o == 0 && cfg_valid_o == 0, "R12 reset idle", {30'h0, cpu_ack_o, cfg_valid_o}, 0);
    rst_ni = 1'b1;
    xfer(0, 12'h000, 2'd2, 0, rd);
    check(rd == 0, "R1 reset addr reg", rd, 0);

    // disabled window
    xfer(1, 12'h000, 2'd2, 32'h0000_0107, rd);
    xfer(0, 12'h000, 2'd2, 0, rd);
    check(rd == 32'h0000_0104, "R1 low bits cleared", rd, 32'h0000_0104);
    c0 = dn_count;
    xfer(0, 12'h004, 2'd2, 0, rd);
    check(rd == 32'hFFFF_FFFF, "R2 disabled read value", rd, 32'hFFFF_FFFF);
    check(dn_count == c0, "R2 no request", 32'(dn_count), 32'(c0));
    xfer(1, 12'h006, 2'd1, 32'hABCD, rd);
    check(dn_count == c0, "R3 write dropped", 32'(dn_count), 32'(c0));
    xfer(0, 12'h000, 2'd2, 0, rd);
    check(rd == 32'h0000_0104, "R3 addr reg untouched", rd, 32'h0000_0104);

    // enabled window sweep
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off++)
        for (int we = 0; we < 2; we++) begin
          ready_lat = (off + sz) % 3;
          rsp_lat   = off % 2;
          a = 32'h8000_0000 | (sz << 16) | (off << 11) | (we << 8) | 32'hB7;
          xfer(1, 12'h000, 2'd2, a, rd);
          xfer(0, 12'h000, 2'd2, 0, rd);
          check(rd == (a & ~32'h3), "R1 readback", rd, a & ~32'h3);
          c0 = dn_count;
          wd = 32'h1122_3344 ^ (32'h0101_0101 * (sz * 8 + off * 2 + we));
          xfer(1'(we), 12'(4 + off), 2'(sz), wd, rd);
          check(dn_count == c0 + 1, "R6 one request", 32'(dn_count), 32'(c0 + 1));
          exp = (a & ~32'h3) | off;
          check(dn_addr == exp, "R4 address", dn_addr, exp);
          check(dn_size == 2'(sz) && dn_we == 1'(we), "R4 size/we", {29'h0, dn_we, dn_size}, 32'((we << 2) | sz));
          if (we) check(dn_wdata == swz(wd, 2'(sz)), "R5 write lanes", dn_wdata, swz(wd, 2'(sz)));
          else check(rd == swz(model_rd(exp), 2'(sz)), "R5 R6 read lanes", rd, swz(model_rd(exp), 2'(sz)));
        end
    check(hold_err == 0, "R6 payload stable", 32'(hold_err), 0);

    // storage sweep
    for (int off = 'hC00; off < 'hE40; off += 4)
      xfer(1, 12'(off), 2'd2, 32'h5A00_0000 | 32'(off * 7), rd);
    for (int off = 'hC00; off < 'hE40; off += 4) begin
      exp = mapped(off) ? (32'h5A00_0000 | 32'(off * 7)) : 32'h0;
      xfer(0, 12'(off), 2'd2, 0, rd);
      if (off == 'hE20) check(rd == exp, "R9 timer", rd, exp);
      else if (off < 'hD00) check(rd == exp, "R7 R10 outbound", rd, exp);
      else check(rd == exp, "R8 R10 inbound", rd, exp);
    end
    xfer(1, 12'h008, 2'd2, 32'hDEAD_BEEF, rd);
    xfer(0, 12'h008, 2'd2, 0, rd);
    check(rd == 0, "R10 offset 8", rd, 0);
    xfer(0, 12'h00C, 2'd2, 0, rd);
    check(rd == 0, "R10 offset C", rd, 0);

    // interrupt sweep
    for (int v = 0; v < 512; v++) begin
      logic [3:0] e;
      @(negedge clk_i);
      slot_irq_i = v[7:0]; stray_irq_i = v[8];
      e = {3'b0, v[8]};
      for (int p = 0; p < 4; p++) begin
        if (v[p])     e[(p + 1) % 4] = 1'b1;
        if (v[4 + p]) e[(p + 2) % 4] = 1'b1;
      end
      #1;
      check(irq_o == e, "R11 fold", {28'h0, irq_o}, {28'h0, e});
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule